// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block decides which of several DMA channels may use the shared bus for its next single data item. Every channel raises a request line and carries a two-bit software priority level held in a small configuration register file inside the block. The arbiter holds exactly one grant at a time. It reconsiders that grant only when the channel's current item completes, which the datapath signals on `item_done`.

Selection takes the highest pending priority level first. Among channels at that level, the lowest channel index wins, and this order is fixed. Because decisions happen only at item boundaries, a more urgent channel can take the bus between two items of a long block. It then waits at most one item transfer of the channel that holds the bus.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is applied and on the first cycles after release, `grant` is all zeros and `grant_valid` is low. Every channel's priority level resets to low (0).
- R2: With no request pending at an arbitration point, `grant_valid` is low and `grant` is all zeros.
- R3: `grant` has at most one bit set, and `grant_valid` is high exactly when one bit is set.
- R4: At an arbitration point, the granted channel is the one at the highest pending priority level. The encoding is 0 = low, 1 = medium, 2 = high, 3 = very high.
- R5: Among pending channels at that highest level, the channel with the lowest index is granted.
- R6: While `grant_valid` is high and `item_done` is low, `grant` does not change. This holds even if requests drop or a more urgent request appears.
- R7: When `item_done` is high while a grant is held, the next grant is chosen from the requests in that cycle and appears on the following cycle. A more urgent channel therefore takes over at the item boundary.
- R8: From idle, a request sampled at a clock edge produces its grant right after that edge, with no cycle of gap.
- R9: A level is written with `cfg_we` high, `cfg_ch` selecting the channel and `cfg_prio` giving the level, and it is stored at the clock edge. It is used from the next arbitration point after the write and never changes a grant that is already held.
- R10: `item_done` has no effect while no grant is held.
- R11: If `item_done` is high while a grant is held and no request is pending, the arbiter goes idle on the next cycle.
- R12: A newly issued grant always goes to a channel whose request was high at the arbitration point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | NUM_CH | Per-channel transfer request |
| item_done | input | 1 | The granted channel's current item finishes this cycle |
| cfg_we | input | 1 | Priority register write strobe |
| cfg_ch | input | CH_W | Channel index for the priority write |
| cfg_prio | input | 2 | Priority level to write |
| grant | output | NUM_CH | One-hot grant |
| grant_valid | output | 1 | A grant is held |

## Verification
The bench sweeps every assignment of levels over four channels against every non-empty request pattern. This exposes a picker that compares levels the wrong way, breaks ties toward the high index, or lets the last channel examined win instead of the best one. Directed sequences raise an urgent request in the middle of an item, drop the holder's request, and rewrite the holder's own level. An arbiter that preempted mid-item would switch grants early. One that held the grant until the request dropped would ignore the boundary. One that applied new levels immediately would pick the wrong successor. Idle cases pulse `item_done` with nothing granted, and a design that treated that pulse as meaningful would issue or lose a grant.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int unsigned PRIO_W  = 2;
  localparam int unsigned NUM_LVL = 1 << PRIO_W;

  typedef enum logic [PRIO_W-1:0] {
    LVL_LOW   = 2'd0,
    LVL_MED   = 2'd1,
    LVL_HIGH  = 2'd2,
    LVL_VHIGH = 2'd3
  } prio_lvl_e;
endpackage

// File: rtl/dma_arb_rst_sync.sv
module dma_arb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_core_n = out_q;
endmodule

// File: rtl/dma_arb_prio_regs.sv
module dma_arb_prio_regs
  import dma_arb_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CH_W   = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [CH_W-1:0]                cfg_ch,
  input  logic [PRIO_W-1:0]              cfg_prio,
  output logic [NUM_CH-1:0][PRIO_W-1:0]  prio_q
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_reg
    logic wr_en;
    assign wr_en = cfg_we && (cfg_ch == CH_W'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_q[c] <= LVL_LOW;
      end else if (wr_en) begin
        prio_q[c] <= cfg_prio;
      end
    end
  end
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
  import dma_arb_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input  logic [NUM_CH-1:0]              req,
  input  logic [NUM_CH-1:0][PRIO_W-1:0]  prio,
  output logic [NUM_CH-1:0]              win,
  output logic                           any
);
  logic [NUM_LVL-1:0][NUM_CH-1:0] lvl_mask;
  logic [NUM_CH-1:0]              top_mask;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign lvl_mask[l][c] = req[c] && (prio[c] == PRIO_W'(l));
    end
  end

  // Ascending scan: the last non-empty level is the most urgent one.
  always_comb begin
    top_mask = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (|lvl_mask[l]) top_mask = lvl_mask[l];
    end
  end

  // Isolate the lowest set bit for the fixed index tie-break.
  assign win = top_mask & (~top_mask + NUM_CH'(1));
  assign any = |req;
endmodule

// File: rtl/dma_arb_grant_ctrl.sv
module dma_arb_grant_ctrl #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] win,
  input  logic              any,
  input  logic              item_done,
  output logic [NUM_CH-1:0] grant,
  output logic              grant_valid
);
  logic [NUM_CH-1:0] grant_q, grant_d;
  logic              valid_q, valid_d;
  logic              arb_en;

  assign arb_en = !valid_q || item_done;

  always_comb begin
    grant_d = any ? win : '0;
    valid_d = any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      valid_q <= 1'b0;
    end else if (arb_en) begin
      grant_q <= grant_d;
      valid_q <= valid_d;
    end
  end

  assign grant       = grant_q;
  assign grant_valid = valid_q;
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req,
  input  logic              item_done,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [PRIO_W-1:0] cfg_prio,
  output logic [NUM_CH-1:0] grant,
  output logic              grant_valid
);
  logic                          rst_core_n;
  logic [NUM_CH-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_CH-1:0]             win;
  logic                          any;

  dma_arb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  dma_arb_prio_regs #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .cfg_we   (cfg_we),
    .cfg_ch   (cfg_ch),
    .cfg_prio (cfg_prio),
    .prio_q   (prio_q)
  );

  dma_arb_pick #(.NUM_CH(NUM_CH)) u_pick (
    .req  (req),
    .prio (prio_q),
    .win  (win),
    .any  (any)
  );

  dma_arb_grant_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .win         (win),
    .any         (any),
    .item_done   (item_done),
    .grant       (grant),
    .grant_valid (grant_valid)
  );
endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk #(
  parameter int unsigned NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] req,
  input logic              item_done,
  input logic [NUM_CH-1:0] grant,
  input logic              grant_valid
);
  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (grant_valid == ($countones(grant) == 1)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !item_done) |=> $stable(grant));

  p_stay_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid && (req == '0)) |=> !grant_valid);

  p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid && (req != '0)) |=> grant_valid);

  p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && item_done && (req == '0)) |=> !grant_valid);

  p_handover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && item_done && (req != '0)) |=> grant_valid);

  p_from_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid || item_done) |=> ((grant & $past(req)) == grant));
endmodule

bind dma_req_arbiter dma_arb_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .req         (req),
  .item_done   (item_done),
  .grant       (grant),
  .grant_valid (grant_valid)
);

// File: tb/test_dma_req_arbiter.sv
module test_dma_req_arbiter;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req;
  logic         item_done;
  logic         cfg_we;
  logic [1:0]   cfg_ch;
  logic [1:0]   cfg_prio;
  logic [N-1:0] grant;
  logic         grant_valid;

  int         n_chk  = 0;
  int         n_fail = 0;
  logic [1:0] mprio [N];

  always #2 clk = ~clk;

  dma_req_arbiter #(.NUM_CH(N)) i_dma_req_arbiter (
    .clk, .rst_n, .req, .item_done, .cfg_we, .cfg_ch, .cfg_prio,
    .grant, .grant_valid
  );

  function automatic logic [N-1:0] expect_win(input logic [N-1:0] r);
    int best = -1;
    int idx  = -1;
    for (int c = 0; c < N; c++) begin
      if (r[c] && int'(mprio[c]) > best) begin
        best = int'(mprio[c]);
        idx  = c;
      end
    end
    return (idx < 0) ? '0 : (N'(1) << idx);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [N-1:0] g_exp, input logic v_exp);
    n_chk++;
    if (grant !== g_exp || grant_valid !== v_exp) begin
      n_fail++;
      $display("FAIL %s: grant=%b valid=%b, expected grant=%b valid=%b",
               tag, grant, grant_valid, g_exp, v_exp);
    end
  endtask

  task automatic wr(input int ch, input logic [1:0] p);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_prio = p;
    tick();
    cfg_we = 1'b0;
    mprio[ch] = p;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req = '0; item_done = 1'b0;
    cfg_we = 1'b0; cfg_ch = '0; cfg_prio = '0;
    for (int c = 0; c < N; c++) mprio[c] = 2'd0;
    repeat (3) tick();
    check("R1 in reset", '0, 1'b0);
    rst_n = 1'b1;
    tick();
    check("R1 first cycle after release", '0, 1'b0);
    repeat (3) tick();
    check("R2 idle no request", '0, 1'b0);

    // R1: all levels reset to low, so plain index order applies (R5).
    req = 4'b1010;
    tick();
    check("R1 reset levels low, R5 lowest index", 4'b0010, 1'b1);
    req = '0; item_done = 1'b1;
    tick();
    check("R11 release to idle", '0, 1'b0);
    item_done = 1'b0;

    // Sweep: every level assignment against every request pattern.
    for (int cfg = 0; cfg < 256; cfg++) begin
      for (int c = 0; c < N; c++) wr(c, 2'((cfg >> (2 * c)) & 3));
      for (int r = 1; r < 16; r++) begin
        req = 4'(r);
        #0;
        if (r == 1) check("R8 no grant before edge", '0, 1'b0);
        tick();
        check("R4/R5 sweep grant", expect_win(4'(r)), 1'b1);
        req = '0; item_done = 1'b1;
        tick();
        check("R11 sweep release", '0, 1'b0);
        item_done = 1'b0;
      end
    end

    // R6 / R7: urgent request mid-block waits for the item boundary.
    wr(0, 2'd3); wr(1, 2'd1); wr(2, 2'd2); wr(3, 2'd0);
    req = 4'b1000;
    tick();
    check("R8 grant from idle", 4'b1000, 1'b1);
    req = 4'b1001;
    tick();
    check("R6 no preempt mid item", 4'b1000, 1'b1);
    req = 4'b0001;
    tick();
    check("R6 hold after holder drops request", 4'b1000, 1'b1);
    item_done = 1'b1;
    tick();
    check("R7 urgent channel takes over at boundary", 4'b0001, 1'b1);

    // R9: rewrite holder's level; applies only at next arbitration point.
    item_done = 1'b0;
    req = 4'b0011;
    wr(0, 2'd0);
    check("R9 held grant unchanged by write", 4'b0001, 1'b1);
    tick();
    check("R9/R6 still held", 4'b0001, 1'b1);
    item_done = 1'b1;
    tick();
    check("R9 new level used at boundary", 4'b0010, 1'b1);
    item_done = 1'b0;

    // R9: write in the same cycle as the boundary uses the old level.
    req = 4'b0101;
    cfg_we = 1'b1; cfg_ch = 2'd0; cfg_prio = 2'd3; item_done = 1'b1;
    tick();
    cfg_we = 1'b0; mprio[0] = 2'd3;
    check("R9 same-cycle write not yet used", 4'b0100, 1'b1);
    tick();
    check("R9 written level used next boundary", 4'b0001, 1'b1);

    // R10: item_done while idle.
    req = '0;
    tick();
    check("R11 idle after last item", '0, 1'b0);
    repeat (3) tick();
    check("R10 item_done ignored when idle", '0, 1'b0);
    item_done = 1'b0;
    req = 4'b0100;
    tick();
    check("R8 grant after idle pulses", 4'b0100, 1'b1);
    req = '0;
    repeat (2) tick();
    check("R6 hold with no requests", 4'b0100, 1'b1);
    item_done = 1'b1;
    tick();
    check("R2 idle when nothing pending", '0, 1'b0);
    item_done = 1'b0;

    finish_run();
  end
endmodule